// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a free-running 64-bit count of whole nanoseconds. On each clock cycle it adds a programmable 32.32 fixed-point increment to the count. The upper 32 bits of the increment are whole nanoseconds. The lower 32 bits are a binary fraction that runs in a 32-bit accumulator, and the carry out of that accumulator adds one more nanosecond to the count. For example, an increment of 0x01_9999_9999 makes the count advance by 1.6 ns per cycle on average. Doubling it gives 3.2 ns per cycle, and multiplying it by twenty gives 32 ns per cycle. An increment of zero stops the clock.

Software reaches the block through a 32-bit register port.

- Reading the low time word takes a snapshot of the whole 64-bit time. A later read of the high time word returns the upper half of that snapshot.
- Writing the low time word only stages a value. The 64-bit time is loaded when the high word is written.
- The increment is staged and committed in the same way, so the counter never runs on half of a new increment.

The running time is also driven on a wide output for capture logic.

Register addresses on `reg_addr_i`:

| Address | Register |
|---|---|
| 0 | Control. Bit 0 is the run enable. |
| 1 | Time, low word |
| 2 | Time, high word |
| 3 | Increment, fraction word |
| 4 | Increment, whole-nanosecond word |

Top module: `tod_counter`

## Requirements
- R1: After reset, `time_o` is 0, the enable bit reads 0, and both increment words read 0.
- R2: On each clock edge where the enable is 1 and no time load occurs, the block adds the increment fraction to the 32-bit accumulator. The count then grows by the increment's whole part plus the accumulator carry. `time_o` shows the new value after that edge, and the carry propagates across all 64 bits.
- R3: While the enable is 0, `time_o` does not change unless a time load occurs.
- R4: While the active increment is 0, `time_o` does not change unless a time load occurs.
- R5: A read of address 1 returns bits 31:0 of `time_o` as it was just before the read edge, and it captures bits 63:32 of that same value. A later read of address 2 returns the captured bits, even if the time has moved on since.
- R6: A write to address 1 on its own leaves `time_o` unchanged. It only stages the low word.
- R7: A write to address 2 loads the time with {written data, last staged low word} and clears the fraction accumulator. The load takes priority over the advance on that edge.
- R8: A write to address 3 on its own does not change the active increment. A write to address 4 makes {written data, last staged fraction} the active increment. Addresses 3 and 4 read back the active increment. An edge that commits a new increment still advances by the old one.
- R9: Writing address 0 sets the enable from data bit 0, and reading address 0 returns {31'b0, enable}. Reads of addresses 5 to 7 return 0.
- R10: With the nominal increment 0x01_9999_9999, five advances from a fresh load give exactly 7 ns. The 2x and 20x scaled increments advance by the matching fixed-point amounts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered; holds until the next read |
| time_o | output | 64 | Live nanosecond count |

## Verification
Every result is due at the first clock edge after its stimulus. A load, an increment commit or an enable change shows on `time_o` right after the edge that samples the write. A read returns its data on `reg_rdata_o` after the edge that samples the strobe, and that data reflects the state before the edge.

The bench drives inputs at the falling edge and updates its own model at the rising edge. The model applies the advance with the old increment and enable before it applies any write. The bench then compares against the model at the next falling edge, so each comparison sees exactly one edge's worth of change.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL    = 3'd0,
    ADDR_TIME_LO = 3'd1,
    ADDR_TIME_HI = 3'd2,
    ADDR_INC_LO  = 3'd3,
    ADDR_INC_HI  = 3'd4
  } tod_addr_e;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int WW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [WW-1:0]     time_i,
  output logic [DW-1:0]     rdata_o,
  output logic              run_en_o,
  output logic [WW-1:0]     inc_o,
  output logic              load_o,
  output logic [WW-1:0]     load_val_o
);
  logic          en_q;
  logic [WW-1:0] inc_q;
  logic [DW-1:0] inc_lo_stage_q, time_lo_stage_q, snap_hi_q, rdata_q;
  logic [DW-1:0] rd_mux;

  logic wr_ctrl, wr_tlo, wr_thi, wr_ilo, wr_ihi;
  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_tlo  = wr_i && (addr_i == ADDR_TIME_LO);
  assign wr_thi  = wr_i && (addr_i == ADDR_TIME_HI);
  assign wr_ilo  = wr_i && (addr_i == ADDR_INC_LO);
  assign wr_ihi  = wr_i && (addr_i == ADDR_INC_HI);

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_CTRL:    rd_mux = {{(DW-1){1'b0}}, en_q};
      ADDR_TIME_LO: rd_mux = time_i[DW-1:0];
      ADDR_TIME_HI: rd_mux = snap_hi_q;
      ADDR_INC_LO:  rd_mux = inc_q[DW-1:0];
      ADDR_INC_HI:  rd_mux = inc_q[WW-1:DW];
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q            <= 1'b0;
      inc_q           <= '0;
      inc_lo_stage_q  <= '0;
      time_lo_stage_q <= '0;
      snap_hi_q       <= '0;
      rdata_q         <= '0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[0];
      if (wr_tlo)  time_lo_stage_q <= wdata_i;
      if (wr_ilo)  inc_lo_stage_q <= wdata_i;
      // commit whole increment atomically
      if (wr_ihi)  inc_q <= {wdata_i, inc_lo_stage_q};
      if (rd_i) begin
        rdata_q <= rd_mux;
        // low read freezes the upper half for a later high read
        if (addr_i == ADDR_TIME_LO) snap_hi_q <= time_i[WW-1:DW];
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign run_en_o   = en_q;
  assign inc_o      = inc_q;
  assign load_o     = wr_thi;
  assign load_val_o = {wdata_i, time_lo_stage_q};
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int WHOLE_W = 32,
  parameter int FRAC_W  = 32,
  parameter int NS_W    = 64,
  localparam int INC_W  = WHOLE_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             load_i,
  input  logic [NS_W-1:0]  load_val_i,
  output logic [NS_W-1:0]  time_o
);
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   ns_step;

  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};
  assign ns_step  = {{(NS_W-WHOLE_W){1'b0}}, inc_i[INC_W-1:FRAC_W]}
                  + {{(NS_W-1){1'b0}}, frac_sum[FRAC_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      ns_q   <= load_val_i;
      frac_q <= '0;
    end else if (run_en_i) begin
      ns_q   <= ns_q + ns_step;
      frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  assign time_o = ns_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int WW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [WW-1:0]     time_o
);
  logic          run_en;
  logic [WW-1:0] inc_val;
  logic          time_load;
  logic [WW-1:0] load_val;

  tod_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .time_i     (time_o),
    .rdata_o    (reg_rdata_o),
    .run_en_o   (run_en),
    .inc_o      (inc_val),
    .load_o     (time_load),
    .load_val_o (load_val)
  );

  tod_accum #(.WHOLE_W(DW), .FRAC_W(DW), .NS_W(WW)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_en_i   (run_en),
    .inc_i      (inc_val),
    .load_i     (time_load),
    .load_val_i (load_val),
    .time_o     (time_o)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic [63:0]       time_o,
  input logic              run_en,
  input logic [63:0]       inc_val,
  input logic              time_load
);
  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !time_load) |=> $stable(time_o));

  // R4
  hold_zero_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_val == 64'd0 && !time_load) |=> $stable(time_o));

  // R2
  step_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en && !time_load) |=>
      ((time_o - $past(time_o)) >= {32'd0, $past(inc_val[63:32])}) &&
      ((time_o - $past(time_o)) <= {32'd0, $past(inc_val[63:32])} + 64'd1));

  // R7
  load_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_TIME_HI) |=> time_o[63:32] == $past(reg_wdata_i));

  // R5
  snap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_TIME_LO) |=> reg_rdata_o == $past(time_o[31:0]));

  // R8
  inc_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_INC_LO) |=> $stable(inc_val));

  // R9
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_CTRL) |=> run_en == $past(reg_wdata_i[0]));
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .time_o      (time_o),
  .run_en      (run_en),
  .inc_val     (inc_val),
  .time_load   (time_load)
);

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] tod;

  int errors = 0, checks = 0;

  // model state
  logic [63:0] m_ns = '0, m_inc = '0;
  logic [31:0] m_frac = '0, m_tlo = '0, m_ilo = '0, m_snap = '0, m_rd = '0;
  logic        m_en = 1'b0;

  always #10 clk = ~clk;

  tod_counter u_tod_counter (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .time_o(tod)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d);
    logic [32:0] fs;
    if (r) begin
      case (a)
        3'd0: m_rd = {31'd0, m_en};
        3'd1: begin m_rd = m_ns[31:0]; m_snap = m_ns[63:32]; end
        3'd2: m_rd = m_snap;
        3'd3: m_rd = m_inc[31:0];
        3'd4: m_rd = m_inc[63:32];
        default: m_rd = '0;
      endcase
    end
    if (w && a == 3'd2) begin
      m_ns = {d, m_tlo};
      m_frac = '0;
    end else if (m_en) begin
      fs = {1'b0, m_frac} + {1'b0, m_inc[31:0]};
      m_frac = fs[31:0];
      m_ns = m_ns + {32'd0, m_inc[63:32]} + {63'd0, fs[32]};
    end
    if (w) begin
      case (a)
        3'd0: m_en = d[0];
        3'd1: m_tlo = d;
        3'd3: m_ilo = d;
        3'd4: m_inc = {d, m_ilo};
        default: ;
      endcase
    end
  endtask

  // inputs change at negedge; model at posedge; compare at next negedge
  task automatic step(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d, input string req);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk(tod === m_ns, req, tod, m_ns);
    if (r) chk(rdata === m_rd, req, {32'd0, rdata}, {32'd0, m_rd});
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 32'd0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tod === 64'd0, "R1", tod, 64'd0);
    step(0, 1, 3'd0, 0, "R1");
    step(0, 1, 3'd3, 0, "R1");
    step(0, 1, 3'd4, 0, "R1");
    // R9 enable, R4 zero increment holds
    step(1, 0, 3'd0, 32'd1, "R9");
    step(0, 1, 3'd0, 0, "R9");
    idle(5, "R4");
    chk(tod === 64'd0, "R4", tod, 64'd0);
    step(0, 1, 3'd6, 0, "R9");
    // R8 staged fraction alone has no effect
    step(1, 0, 3'd3, 32'h9999_9999, "R8");
    idle(3, "R8");
    step(0, 1, 3'd3, 0, "R8");
    chk(tod === 64'd0, "R8", tod, 64'd0);
    // R10 nominal increment: commit, then 5 advances give 7
    step(1, 0, 3'd4, 32'd1, "R8");
    chk(tod === 64'd0, "R8", tod, 64'd0);
    idle(5, "R10");
    chk(tod === 64'd7, "R10", tod, 64'd7);
    step(0, 1, 3'd4, 0, "R8");
    // R3 disable holds
    step(1, 0, 3'd0, 32'd0, "R9");
    idle(4, "R3");
    // R6 low write alone, R7 load across word boundary
    step(1, 0, 3'd1, 32'hFFFF_FFF0, "R6");
    idle(2, "R6");
    step(1, 0, 3'd2, 32'd0, "R7");
    chk(tod === 64'h0000_0000_FFFF_FFF0, "R7", tod, 64'h0000_0000_FFFF_FFF0);
    // R10 20x increment, R2 carry into upper half
    step(1, 0, 3'd3, 32'hFFFF_FFF4, "R10");
    step(1, 0, 3'd4, 32'h0000_001F, "R10");
    step(1, 0, 3'd0, 32'd1, "R9");
    idle(1, "R2");
    chk(tod === 64'h1_0000_000F, "R2", tod, 64'h1_0000_000F);
    idle(3, "R10");
    // R5 snapshot then advance then high read
    step(0, 1, 3'd1, 0, "R5");
    idle(4, "R5");
    step(0, 1, 3'd2, 0, "R5");
    // R7 load wins while running
    step(1, 0, 3'd1, 32'h1234_5678, "R7");
    step(1, 0, 3'd2, 32'h0000_0ABC, "R7");
    chk(tod === 64'h0000_0ABC_1234_5678, "R7", tod, 64'h0000_0ABC_1234_5678);
    // R10 2x increment
    step(1, 0, 3'd3, 32'h3333_3332, "R10");
    step(1, 0, 3'd4, 32'd3, "R10");
    idle(10, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [2:0] a = 3'($urandom_range(0, 5));
      logic [31:0] d = $urandom();
      if (a == 3'd2) d = d & 32'h3FFF_FFFF;
      if (a == 3'd0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      if (a == 3'd4) begin
        case ($urandom_range(0, 3))
          0: d = 32'd1;
          1: d = 32'd3;
          2: d = 32'h1F;
          default: d = d & 32'hFF;
        endcase
      end
      if (op < 3)      step(1, 0, a, d, "R2");
      else if (op < 6) step(0, 1, a, 0, "R5");
      else             step(0, 0, 3'd0, 0, "R2");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule